// File: doc/BRIEF.md
# Shared Time Base and Watchdog Timer

This block produces a slow periodic time base from a source oscillator and builds a watchdog on top of the same counter chain. Both can drive a single active-low, open-drain interrupt pin. Each period of the source oscillator is presented as a one-cycle pulse on `src_tick`. A source-select input says which oscillator is present.

The two fast sources (internal RC and external clock, nominally 256 kHz) pass through a fixed divide-by-8 prescaler. The crystal source (nominally 32 kHz) feeds the counter directly. Eight rate settings choose which stage of the counter is the time-base output. The watchdog adds two stages that count completed time-base periods. It latches a timeout flag on the fourth period.

Decoded single-cycle command strobes control the block:
- run or stop the counter,
- route the time base or the watchdog flag to the pin,
- clear the counter and the watchdog,
- enable or release the pin,
- load a rate.

A system-on level halts the counters for the RC and crystal sources. The external source ignores it. All control pins are plain levels or strobes. There is no streaming data path and no handshake.

Top module: `tbase_wdt`

## Requirements
- R1: After reset the counter is stopped, nothing is routed to the pin, the pin is released (`irq_oe`=0) and the rate is 7.
- R2: With `src_sel`=2'b01 (crystal) each allowed `src_tick` advances the counter by one. With any other code (2'b00 RC, 2'b10 external, 2'b11 treated as RC), eight allowed ticks advance it by one.
- R3: Rate n (0..7) selects counter bit CNT_W-1-n as the time-base output. That output is low for 2^(CNT_W-1-n) counter steps after a clear and then high for the same number of steps, repeating.
- R4: In timer routing with the pin enabled, `irq_oe` equals the selected time-base output.
- R5: In watchdog routing, the timeout flag sets when the selected output completes its fourth full period. It stays set, and `irq_oe` stays 1 while the pin is enabled, until a watchdog clear.
- R6: Watchdog clear zeroes the prescaler, the counter, the watchdog stages and the flag. Timer clear zeroes only the prescaler and counter, and keeps the watchdog stage count.
- R7: Watchdog-disable stops the counter and drops watchdog routing. Watchdog-enable runs it with watchdog routing. Timer-enable runs it with timer routing. Timer-disable drops timer routing only.
- R8: IRQ-disable releases the pin (`irq_oe`=0) without losing the flag. IRQ-enable drives it again from the current state.
- R9: With `sys_on`=0 the counters hold for codes other than 2'b10. With 2'b10 (external), `sys_on` has no effect.
- R10: A clear arriving in the same cycle as a tick or an enable takes effect first: that tick is lost and the enable still applies.
- R11: `irq_o` is always 0. The pin is pulled low only through `irq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | One pulse per source oscillator period |
| src_sel | input | 2 | Source: 00 RC, 01 crystal, 10 external, 11 as RC |
| sys_on | input | 1 | System enable level |
| cmd_timer_en | input | 1 | Run and route time base to pin |
| cmd_timer_dis | input | 1 | Drop time-base routing |
| cmd_wdt_en | input | 1 | Run and route watchdog flag to pin |
| cmd_wdt_dis | input | 1 | Stop counter, drop watchdog routing |
| cmd_clr_timer | input | 1 | Clear prescaler and counter |
| cmd_clr_wdt | input | 1 | Clear counter, watchdog and flag |
| cmd_irq_en | input | 1 | Enable pin drive |
| cmd_irq_dis | input | 1 | Release pin |
| cmd_rate_set | input | 1 | Load `rate_val` |
| rate_val | input | 3 | Rate code n |
| irq_o | output | 1 | Pin drive level (constant low) |
| irq_oe | output | 1 | Pin output enable: 1 pulls the line low |

## Verification
A wrong counter or prescaler value shows up in timer routing as a shifted or stretched square wave on `irq_oe`. The error is visible within one half-period of the selected rate.

Errors in the watchdog stages or the flag appear only when the timeout fires early, late or not at all. They therefore show after at most four periods. A flag that is not held shows the next cycle after a release.

Routing, enable and clear mistakes change `irq_oe` in the cycle after the offending strobe. Comparing the pin every cycle against an independent model catches all of these cases.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  typedef enum logic [1:0] {
    SRC_RC   = 2'b00,
    SRC_XTAL = 2'b01,
    SRC_EXT  = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    RT_NONE  = 2'b00,
    RT_TIMER = 2'b01,
    RT_WDT   = 2'b10
  } route_e;
endpackage

// File: rtl/tbw_prescale.sv
module tbw_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             bypass,
  output logic             tick,
  output logic [DIV_W-1:0] pre_cnt
);
  logic [DIV_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)       pre_q <= '0;
    else if (adv && !bypass) pre_q <= pre_q + 1'b1;
  end

  // one base tick per 2^DIV_W source ticks, or every tick when bypassed
  assign tick    = adv && (bypass || (&pre_q));
  assign pre_cnt = pre_q;
endmodule

// File: rtl/tbw_chain.sv
module tbw_chain #(
  parameter int CNT_W  = 15,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic [CNT_W-1:0]  cnt,
  output logic              tb_out,
  output logic              period_end
);
  localparam int NRATE = 1 << RATE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [NRATE-1:0] tap;
  logic [NRATE-1:0] wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NRATE; g++) begin : g_tap
    localparam int K = CNT_W - 1 - g;
    assign tap[g]  = cnt_q[K];
    assign wrap[g] = &cnt_q[K:0];
  end

  assign cnt        = cnt_q;
  assign tb_out     = tap[rate];
  assign period_end = tick && !clr && wrap[rate];
endmodule

// File: rtl/tbw_watch.sv
module tbw_watch #(
  parameter int WD_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic flag
);
  logic [WD_W-1:0] stg_q;
  logic            flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      stg_q  <= '0;
      flag_q <= 1'b0;
    end else if (step) begin
      stg_q <= stg_q + 1'b1;
      if (&stg_q) flag_q <= 1'b1;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/tbase_wdt.sv
module tbase_wdt #(
  parameter int CNT_W  = 15,
  parameter int RATE_W = 3,
  parameter int DIV_W  = 3,
  parameter int WD_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic [1:0]        src_sel,
  input  logic              sys_on,
  input  logic              cmd_timer_en,
  input  logic              cmd_timer_dis,
  input  logic              cmd_wdt_en,
  input  logic              cmd_wdt_dis,
  input  logic              cmd_clr_timer,
  input  logic              cmd_clr_wdt,
  input  logic              cmd_irq_en,
  input  logic              cmd_irq_dis,
  input  logic              cmd_rate_set,
  input  logic [RATE_W-1:0] rate_val,
  output logic              irq_o,
  output logic              irq_oe
);
  import tbw_pkg::*;

  route_e             route_q;
  logic               run_q;
  logic               irq_en_q;
  logic [RATE_W-1:0]  rate_q;

  logic               halt;
  logic               adv;
  logic               clr_cnt;
  logic               tick32;
  logic [DIV_W-1:0]   pre_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tb_out;
  logic               period_end;
  logic               flag_q;

  assign halt    = !sys_on && (src_sel != SRC_EXT);
  assign adv     = run_q && !halt && src_tick;
  assign clr_cnt = cmd_clr_timer || cmd_clr_wdt;

  tbw_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_cnt),
    .adv     (adv),
    .bypass  (src_sel == SRC_XTAL),
    .tick    (tick32),
    .pre_cnt (pre_q)
  );

  tbw_chain #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_cnt),
    .tick       (tick32),
    .rate       (rate_q),
    .cnt        (cnt_q),
    .tb_out     (tb_out),
    .period_end (period_end)
  );

  tbw_watch #(.WD_W(WD_W)) u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd_clr_wdt),
    .step  (period_end && (route_q == RT_WDT)),
    .flag  (flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q  <= RT_NONE;
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
      rate_q   <= '1;
    end else begin
      if (cmd_timer_dis && route_q == RT_TIMER) route_q <= RT_NONE;
      if (cmd_wdt_dis) begin
        run_q <= 1'b0;
        if (route_q == RT_WDT) route_q <= RT_NONE;
      end
      if (cmd_timer_en) begin
        run_q   <= 1'b1;
        route_q <= RT_TIMER;
      end
      if (cmd_wdt_en) begin
        run_q   <= 1'b1;
        route_q <= RT_WDT;
      end
      if (cmd_irq_dis) irq_en_q <= 1'b0;
      if (cmd_irq_en)  irq_en_q <= 1'b1;
      if (cmd_rate_set) rate_q <= rate_val;
    end
  end

  assign irq_o  = 1'b0;
  assign irq_oe = irq_en_q && (((route_q == RT_TIMER) && tb_out) ||
                               ((route_q == RT_WDT) && flag_q));
endmodule

// File: rtl/tbase_wdt_chk.sv
module tbase_wdt_chk #(
  parameter int CNT_W = 15,
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       src_sel,
  input logic             sys_on,
  input logic             cmd_clr_timer,
  input logic             cmd_clr_wdt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [DIV_W-1:0] pre_q,
  input logic             run_q,
  input logic             flag_q,
  input logic             irq_en_q,
  input logic             irq_oe
);
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_timer || cmd_clr_wdt) |=> (cnt_q == '0 && pre_q == '0));

  p_hold_sysoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_on && src_sel != 2'b10 && !cmd_clr_timer && !cmd_clr_wdt) |=> $stable(cnt_q));

  p_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_clr_timer && !cmd_clr_wdt) |=> $stable(cnt_q));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !cmd_clr_wdt) |=> flag_q);

  p_xtal_nopre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b01 && !cmd_clr_timer && !cmd_clr_wdt) |=> $stable(pre_q));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_clr_timer && !cmd_clr_wdt) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq_oe);
endmodule

bind tbase_wdt tbase_wdt_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_sel       (src_sel),
  .sys_on        (sys_on),
  .cmd_clr_timer (cmd_clr_timer),
  .cmd_clr_wdt   (cmd_clr_wdt),
  .cnt_q         (cnt_q),
  .pre_q         (pre_q),
  .run_q         (run_q),
  .flag_q        (flag_q),
  .irq_en_q      (irq_en_q),
  .irq_oe        (irq_oe)
);

// File: tb/tbase_wdt_bench.sv
module tbase_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_tick = 1'b0;
  logic [1:0] src_sel = 2'b01;
  logic sys_on = 1'b1;
  logic c_ten = 0, c_tdis = 0, c_wen = 0, c_wdis = 0, c_ctm = 0, c_cwd = 0;
  logic c_ien = 0, c_idis = 0, c_rate = 0;
  logic [2:0] rate_val = 3'd7;
  logic irq_o, irq_oe;

  int checks = 0;
  int fails = 0;
  bit wd_fired = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_wdt #(.CNT_W(CW)) u_tbase_wdt (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel), .sys_on(sys_on),
    .cmd_timer_en(c_ten), .cmd_timer_dis(c_tdis), .cmd_wdt_en(c_wen), .cmd_wdt_dis(c_wdis),
    .cmd_clr_timer(c_ctm), .cmd_clr_wdt(c_cwd), .cmd_irq_en(c_ien), .cmd_irq_dis(c_idis),
    .cmd_rate_set(c_rate), .rate_val(rate_val), .irq_o(irq_o), .irq_oe(irq_oe));

  // independent reference model of the requirements
  int m_pre, m_cnt, m_wd, m_route, m_rate;
  bit m_run, m_flag, m_ien;

  function automatic int kbit(input int rate);
    return CW - 1 - rate;
  endfunction

  function automatic bit exp_oe();
    bit tb;
    tb = ((m_cnt >> kbit(m_rate)) & 1) != 0;
    return m_ien && ((m_route == 1 && tb) || (m_route == 2 && m_flag));
  endfunction

  always @(posedge clk) begin
    bit halt, adv, t32, clr, pend;
    int mask;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_wd = 0; m_route = 0; m_rate = 7;
      m_run = 0; m_flag = 0; m_ien = 0;
    end else begin
      halt = !sys_on && src_sel != 2'b10;
      adv  = m_run && !halt && src_tick;
      clr  = c_ctm || c_cwd;
      t32  = adv && (src_sel == 2'b01 || m_pre == 7);
      mask = (1 << (kbit(m_rate) + 1)) - 1;
      pend = t32 && !clr && ((m_cnt & mask) == mask);
      if (clr) m_pre = 0;
      else if (adv && src_sel != 2'b01) m_pre = (m_pre + 1) % 8;
      if (clr) m_cnt = 0;
      else if (t32) m_cnt = (m_cnt + 1) % (1 << CW);
      if (c_cwd) begin m_wd = 0; m_flag = 0; end
      else if (pend && m_route == 2) begin
        if (m_wd == 3) m_flag = 1;
        m_wd = (m_wd + 1) % 4;
      end
      if (c_tdis && m_route == 1) m_route = 0;
      if (c_wdis) begin m_run = 0; if (m_route == 2) m_route = 0; end
      if (c_ten) begin m_run = 1; m_route = 1; end
      if (c_wen) begin m_run = 1; m_route = 2; end
      if (c_idis) m_ien = 0;
      if (c_ien) m_ien = 1;
      if (c_rate) m_rate = rate_val;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: commands set before the call are consumed at the posedge
  task automatic cyc(input bit tick_on);
    src_tick = tick_on;
    @(negedge clk);
    check(tag, irq_oe, exp_oe());
    if (irq_oe) wd_fired = 1;
    {c_ten, c_tdis, c_wen, c_wdis, c_ctm, c_cwd, c_ien, c_idis, c_rate} = '0;
  endtask

  task automatic run(input int n, input int tick_pct);
    for (int i = 0; i < n; i++) cyc(($urandom % 100) < tick_pct);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R11 constant low drive
    tag = "R1"; cyc(1);
    check("R11", irq_o, 0);
    // R1: stopped at reset, rate 7: enabling pin alone shows nothing
    c_ien = 1; cyc(1); run(20, 100);

    // R4 / R2: crystal, timer routing, rate 7 -> 4-step square wave
    tag = "R4"; src_sel = 2'b01; c_ctm = 1; c_ten = 1; cyc(0);
    run(40, 100);
    // R2: RC source -> prescale by 8
    tag = "R2"; src_sel = 2'b00; c_ctm = 1; cyc(0); run(120, 100);
    src_sel = 2'b11; run(60, 80);
    // R3: other rates
    tag = "R3"; src_sel = 2'b01; rate_val = 3'd5; c_rate = 1; c_ctm = 1; cyc(0);
    run(100, 100);
    rate_val = 3'd0; c_rate = 1; cyc(1); run(1100, 100);

    // R5: watchdog timeout at rate 7, crystal: 4 periods of 4 steps
    tag = "R5"; rate_val = 3'd7; c_rate = 1; c_cwd = 1; c_wen = 1; cyc(0);
    wd_fired = 0;
    run(15, 100);
    check("R5", irq_oe, 0);
    cyc(1);
    check("R5", irq_oe, 1);
    run(30, 100);
    check("R5", irq_oe, 1);

    // R8: release keeps flag
    tag = "R8"; c_idis = 1; cyc(1); check("R8", irq_oe, 0); run(10, 100);
    c_ien = 1; cyc(1); check("R8", irq_oe, 1);

    // R6: clear watchdog releases; clear timer keeps stage count
    tag = "R6"; c_cwd = 1; cyc(1); check("R6", irq_oe, 0);
    run(9, 100); c_ctm = 1; cyc(1); run(30, 100);
    c_cwd = 1; cyc(0);

    // R9: system off halts RC, not external
    tag = "R9"; src_sel = 2'b00; sys_on = 0; c_ten = 1; cyc(1); run(200, 100);
    src_sel = 2'b10; run(200, 100);
    sys_on = 1; src_sel = 2'b01;

    // R10: clear with enable and tick same cycle
    tag = "R10"; c_wdis = 1; cyc(1);
    c_ctm = 1; c_ten = 1; cyc(1); check("R10", irq_oe, 0); run(12, 100);

    // R7: disable stops the counter
    tag = "R7"; c_wdis = 1; cyc(1); run(20, 100);
    c_wen = 1; cyc(1); run(20, 100); c_tdis = 1; cyc(1); run(10, 100);

    // random mix
    tag = "R4";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom % 200;
      case (r)
        0: c_ten = 1;  1: c_tdis = 1; 2: c_wen = 1; 3: c_wdis = 1;
        4: c_ctm = 1;  5: c_cwd = 1;  6: c_ien = 1; 7: c_idis = 1;
        8: begin c_rate = 1; rate_val = 3'(4 + $urandom % 4); end
        9: src_sel = 2'($urandom % 4);
        10: sys_on = ~sys_on;
        default: ;
      endcase
      cyc(($urandom % 4) != 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule